// File: doc/BRIEF.md
# Station-Management Master for PHY Registers

This block is the management-side master for reading and writing Ethernet PHY registers over a two-wire management link: a slow clock (MDC) and a shared bidirectional data line (MDIO). A host loads a PHY address, a register address, a direction flag and, for writes, a 16-bit data word, then pulses a start input. The block sets its busy flag, serialises a complete clause-22 management frame, and clears busy when the frame is over. For a read, the 16 bits returned by the PHY are then available on the read-data output.

MDC is derived from the host clock by a divider. A 3-bit range code picks the divide ratio from a fixed table, and the table is not in ascending order. Each ratio is meant for one band of host clock frequency, so that MDC stays between 1 and 2.5 MHz. The range code and all command fields are captured when a frame starts and held until it ends.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, `busy` is 0, `mdc` is 0, `mdio_oe` is 0 and `rd_data` is 0 until the first read completes.
- R2: The MDC period in host clocks, with equal high and low halves starting low, is set by the range code: 0 gives 42, 1 gives 62, 2 gives 16, 3 gives 26, 4 gives 102, 5 gives 124.
- R3: Range codes 6 and 7 behave exactly like code 5 (divide by 124).
- R4: A `start` pulse while idle sets `busy` on the next clock edge. `busy` then stays high for exactly 64 MDC periods and clears by itself.
- R5: While `busy` is high, `start`, the command fields and the range code have no effect on the frame in progress.
- R6: A write frame sends the following bits MSB first: 32 ones, start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, then the 16 data bits. `mdio_oe` is high for the whole frame.
- R7: A read frame uses opcode 10. `mdio_oe` is high for frame bits 0 to 45 and low from the first turnaround bit (bit 46) to the end of the frame.
- R8: `mdio_o` and `mdio_oe` take their first bit value when the frame starts and change only at MDC falling edges.
- R9: On a read, `mdio_i` is sampled at the rising MDC edge of frame bits 48 to 63, first sample into the MSB. After `busy` clears, `rd_data` holds the result, and write frames leave it unchanged.
- R10: The range code is captured when a frame starts, so a change during the frame does not alter its MDC period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_range | input | 3 | MDC divide-ratio code |
| start | input | 1 | Pulse to launch a frame (ignored while busy) |
| cmd_write | input | 1 | 1 = write frame, 0 = read frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address within the PHY |
| cmd_wdata | input | 16 | Data word for a write |
| busy | output | 1 | Frame in progress |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume three things about the block's surroundings. `start` and the command inputs change only between host clock edges. A PHY drives `mdio_i` only while the master has released the line. `mdio_i` is steady for the whole of each read data bit. The bench's PHY model changes `mdio_i` only at bit boundaries and returns ones while the line is not in its data phase. Stimulus goes out on the falling host edge. Mid-frame changes to `start`, the fields and the range code test that nothing leaks into a running frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int RANGE_W  = 3;
   localparam int MAX_DIV  = 124;

   localparam logic [1:0] SOF_BITS = 2'b01;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] TA_WRITE = 2'b10;

   // MDC divide ratio for a range code; the order follows host-clock bands.
   function automatic int unsigned div_for_code(input logic [RANGE_W-1:0] code);
      case (code)
         3'd0:    return 42;
         3'd1:    return 62;
         3'd2:    return 16;
         3'd3:    return 26;
         3'd4:    return 102;
         default: return 124;
      endcase
   endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] half,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);

   logic [CNT_W-1:0] cnt;
   logic             wrap;

   assign wrap = en && (cnt == half - CNT_W'(1));
   assign rise = wrap && !mdc;
   assign fall = wrap && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!en) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt < half));

   p_half_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !$past(wrap)) |-> $stable(mdc));

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
   import mdio_pkg::*;
#(
   parameter int PHY_AW  = 5,
   parameter int REG_AW  = 5,
   parameter int DATA_W  = 16,
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              cmd_write,
   input  logic [PHY_AW-1:0] cmd_phy,
   input  logic [REG_AW-1:0] cmd_reg,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              rise,
   input  logic              fall,
   input  logic              mdio_in,
   output logic              busy,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rd_data
);

   localparam int FRAME_LEN = PRE_LEN + 4 + PHY_AW + REG_AW + 2 + DATA_W;
   localparam int TA_POS    = PRE_LEN + 4 + PHY_AW + REG_AW;
   localparam int DATA_POS  = TA_POS + 2;
   localparam int IDX_W     = $clog2(FRAME_LEN + 1);

   logic [FRAME_LEN-1:0] shreg;
   logic [FRAME_LEN-1:0] frame_img;
   logic [IDX_W-1:0]     bit_idx;
   logic                 is_read;
   logic                 last_bit;
   logic                 enter_ta;

   always_comb begin
      if (cmd_write)
         frame_img = {{PRE_LEN{1'b1}}, SOF_BITS, OP_WRITE, cmd_phy, cmd_reg,
                      TA_WRITE, cmd_wdata};
      else
         frame_img = {{PRE_LEN{1'b1}}, SOF_BITS, OP_READ, cmd_phy, cmd_reg,
                      2'b11, {DATA_W{1'b1}}};
   end

   assign last_bit = (bit_idx == IDX_W'(FRAME_LEN - 1));
   assign enter_ta = (bit_idx == IDX_W'(TA_POS - 1));
   assign mdio_o   = shreg[FRAME_LEN-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_idx <= '0;
         is_read <= 1'b0;
         busy    <= 1'b0;
         mdio_oe <= 1'b0;
      end else if (launch) begin
         shreg   <= frame_img;
         bit_idx <= '0;
         is_read <= !cmd_write;
         busy    <= 1'b1;
         mdio_oe <= 1'b1;
      end else if (busy && fall) begin
         if (last_bit) begin
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
            bit_idx <= '0;
         end else begin
            shreg   <= shreg << 1;
            bit_idx <= bit_idx + IDX_W'(1);
            if (is_read && enter_ta)
               mdio_oe <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (busy && rise && is_read && (bit_idx >= IDX_W'(DATA_POS)))
         rd_data <= {rd_data[DATA_W-2:0], mdio_in};
   end

   p_launch_sets_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> busy);

   p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_idx < IDX_W'(FRAME_LEN));

   p_read_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && is_read && (bit_idx >= IDX_W'(TA_POS))) |-> !mdio_oe);

   p_write_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !is_read) |-> mdio_oe);

   p_change_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy && !$past(fall)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   p_dir_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> $stable(is_read));

   p_rd_held_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> $stable(rd_data));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int PHY_AW    = 5,
   parameter int REG_AW    = 5,
   parameter int DATA_W    = 16,
   parameter int PRE_LEN   = 32,
   parameter int IN_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RANGE_W-1:0] clk_range,
   input  logic               start,
   input  logic               cmd_write,
   input  logic [PHY_AW-1:0]  cmd_phy,
   input  logic [REG_AW-1:0]  cmd_reg,
   input  logic [DATA_W-1:0]  cmd_wdata,
   output logic               busy,
   output logic [DATA_W-1:0]  rd_data,
   output logic               mdc,
   output logic               mdio_o,
   output logic               mdio_oe,
   input  logic               mdio_i
);

   localparam int CNT_W = $clog2(MAX_DIV / 2 + 1);

   if (PHY_AW < 1 || REG_AW < 1) begin : g_bad_addr
      $error("address widths must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be at least 1");
   end
   if (IN_STAGES < 0 || IN_STAGES > 3) begin : g_bad_sync
      $error("IN_STAGES must be 0 to 3");
   end

   logic             launch;
   logic [CNT_W-1:0] half_q;
   logic             tick_rise;
   logic             tick_fall;
   logic             mdio_s;

   assign launch = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         half_q <= CNT_W'(MAX_DIV / 2);
      else if (launch)
         half_q <= CNT_W'(div_for_code(clk_range) / 2);
   end

   if (IN_STAGES == 0) begin : g_in_direct
      assign mdio_s = mdio_i;
   end else begin : g_in_sync
      logic [IN_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sync_q <= '1;
         else
            sync_q <= {sync_q[IN_STAGES-2 >= 0 ? IN_STAGES-2 : 0 : 0], mdio_i};
      end
      assign mdio_s = sync_q[IN_STAGES-1];
   end

   mdio_clkdiv #(.CNT_W(CNT_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (busy),
      .half  (half_q),
      .mdc   (mdc),
      .rise  (tick_rise),
      .fall  (tick_fall)
   );

   mdio_frame #(
      .PHY_AW  (PHY_AW),
      .REG_AW  (REG_AW),
      .DATA_W  (DATA_W),
      .PRE_LEN (PRE_LEN)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .cmd_write (cmd_write),
      .cmd_phy   (cmd_phy),
      .cmd_reg   (cmd_reg),
      .cmd_wdata (cmd_wdata),
      .rise      (tick_rise),
      .fall      (tick_fall),
      .mdio_in   (mdio_s),
      .busy      (busy),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .rd_data   (rd_data)
   );

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   p_range_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> $stable(half_q));

   p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && $past(start) && busy) |-> $stable(half_q));

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  clk_range = 3'd0;
   logic        start = 1'b0;
   logic        cmd_write = 1'b0;
   logic [4:0]  cmd_phy = '0;
   logic [4:0]  cmd_reg = '0;
   logic [15:0] cmd_wdata = '0;
   logic        busy;
   logic [15:0] rd_data;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i = 1'b1;

   always #5 clk = ~clk;

   mdio_master u_mdio_master (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_range (clk_range),
      .start     (start),
      .cmd_write (cmd_write),
      .cmd_phy   (cmd_phy),
      .cmd_reg   (cmd_reg),
      .cmd_wdata (cmd_wdata),
      .busy      (busy),
      .rd_data   (rd_data),
      .mdc       (mdc),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .mdio_i    (mdio_i)
   );

   int checks = 0;
   int fails  = 0;

   // reference model state
   int          m_t = -1;
   int          m_n = 124;
   logic        m_wr = 1'b0;
   logic [63:0] m_frame = '0;
   logic [15:0] m_rdval = '0;
   logic [15:0] m_rd = '0;
   logic [15:0] phy_val = 16'h0000;

   function automatic int ratio(input logic [2:0] c);
      int r;
      r = (c == 3'd0) ? 42 : (c == 3'd1) ? 62 : (c == 3'd2) ? 16 :
          (c == 3'd3) ? 26 : (c == 3'd4) ? 102 : 124;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_t  <= -1;
         m_rd <= '0;
      end else if (m_t < 0) begin
         if (start) begin
            m_t     <= 0;
            m_n     <= ratio(clk_range);
            m_wr    <= cmd_write;
            m_rdval <= phy_val;
            if (cmd_write)
               m_frame <= {32'hFFFF_FFFF, 2'b01, 2'b01, cmd_phy, cmd_reg, 2'b10, cmd_wdata};
            else
               m_frame <= {32'hFFFF_FFFF, 2'b01, 2'b10, cmd_phy, cmd_reg, 18'h0};
         end
      end else if (m_t + 1 == 64 * m_n) begin
         m_t <= -1;
         if (!m_wr) m_rd <= m_rdval;
      end else begin
         m_t <= m_t + 1;
      end
   end

   // PHY model: returns m_rdval during the data phase of reads, idle-high otherwise
   always @(negedge clk) begin
      int idx;
      idx = (m_t >= 0) ? m_t / m_n : 0;
      if (m_t >= 0 && !m_wr && idx >= 48) mdio_i = m_rdval[63 - idx];
      else mdio_i = 1'b1;
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         int idx;
         logic e_mdc, e_oe;
         if (m_t >= 0) begin
            idx   = m_t / m_n;
            e_mdc = ((m_t / (m_n / 2)) % 2) == 1;
            e_oe  = m_wr || (idx < 46);
            chk(busy == 1'b1, "R4 busy", busy, 1);
            chk(mdc == e_mdc, "R2 R3 R10 mdc", mdc, e_mdc);
            chk(mdio_oe == e_oe, "R6 R7 oe", mdio_oe, e_oe);
            if (e_oe) chk(mdio_o == m_frame[63 - idx], "R5 R6 R8 mdio_o", mdio_o, m_frame[63 - idx]);
         end else begin
            chk(busy == 1'b0, "R1 R4 busy idle", busy, 0);
            chk(mdc == 1'b0, "R1 mdc idle", mdc, 0);
            chk(mdio_oe == 1'b0, "R1 oe idle", mdio_oe, 0);
            chk(rd_data == m_rd, "R9 rd_data", rd_data, m_rd);
         end
      end
   end

   task automatic run_frame(input logic [2:0] code, input logic wr, input logic [4:0] phy,
                            input logic [4:0] rg, input logic [15:0] wd, input logic [15:0] pv,
                            input bit disturb);
      @(negedge clk);
      clk_range = code; cmd_write = wr; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
      phy_val = pv; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (disturb) begin
         repeat (300) @(negedge clk);
         // R5 R10: everything changes while busy; the frame must not notice
         clk_range = ~code; cmd_write = ~wr; cmd_phy = ~phy; cmd_reg = ~rg;
         cmd_wdata = ~wd; phy_val = ~pv; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (m_t >= 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0 && mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset", {busy, mdc, mdio_oe}, 0);
      chk(rd_data == 16'h0, "R1 reset rd_data", rd_data, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_frame(3'd2, 1'b1, 5'h01, 5'h00, 16'hA55A, 16'h0000, 1'b0);  // R6 write /16
      run_frame(3'd3, 1'b0, 5'h1F, 5'h02, 16'h0000, 16'hC3E1, 1'b0);  // R7 R9 read /26
      chk(rd_data == 16'hC3E1, "R9 read result", rd_data, 16'hC3E1);
      run_frame(3'd0, 1'b1, 5'h10, 5'h1F, 16'h8001, 16'h0000, 1'b0);  // R2 /42, R9 hold
      chk(rd_data == 16'hC3E1, "R9 held after write", rd_data, 16'hC3E1);
      run_frame(3'd1, 1'b0, 5'h05, 5'h11, 16'h0000, 16'h1234, 1'b0);  // R2 /62
      run_frame(3'd4, 1'b1, 5'h0A, 5'h15, 16'hFFFF, 16'h0000, 1'b0);  // R2 /102
      run_frame(3'd5, 1'b0, 5'h00, 5'h01, 16'h0000, 16'h8000, 1'b0);  // R2 /124
      run_frame(3'd6, 1'b1, 5'h03, 5'h04, 16'h0001, 16'h0000, 1'b0);  // R3 code 6
      run_frame(3'd7, 1'b0, 5'h07, 5'h08, 16'h0000, 16'h0F0F, 1'b0);  // R3 code 7
      chk(rd_data == 16'h0F0F, "R3 R9 read at code 7", rd_data, 16'h0F0F);
      run_frame(3'd2, 1'b0, 5'h12, 5'h0C, 16'h0000, 16'h5AA5, 1'b1);  // R5 R10 disturbed read
      chk(rd_data == 16'h5AA5, "R5 R9 disturbed read", rd_data, 16'h5AA5);
      run_frame(3'd3, 1'b1, 5'h19, 5'h06, 16'h3C3C, 16'h0000, 1'b1);  // R5 R10 disturbed write
      chk(rd_data == 16'h5AA5, "R9 unchanged by write", rd_data, 16'h5AA5);
      chk(busy == 1'b0, "R4 busy cleared at end", busy, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule